// File: doc/BRIEF.md
# Field-Programmable Cascaded-Lookup State Machine

This block is a finite state machine whose transition function lives in small writable memories, so its behaviour can be replaced at run time by rewriting those memories. The block does not need to be rebuilt. The machine holds an `ST_W`-bit state and watches `NUM_IN` binary inputs. Each clock it works out its next state through `LEVELS` identical stages wired in a chain.

Inside a stage, an input-pick memory is addressed by the partial state arriving at that stage. The word it returns is the index of the one input bit the stage looks at. A successor memory is then addressed by the arriving partial state with that input bit appended below it, and it returns the partial state handed to the next stage. The first stage starts from the current state. The last stage's result is loaded into the state register on the next rising clock edge.

A single write port fills any word of any memory, one word per cycle. The output presents the state with one constant zero bit above it. The reset is asynchronous and active low, and its release is synchronised inside the block. Memory writes are honoured from the third rising edge after `rst_n` goes high.

Top module: `rfsm_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `y_o` reads 0, and every word of every memory is cleared to 0; a reset in mid-run discards all earlier programming.
- R2: With every memory word at zero, the state stays 0 for every one of the 2^`NUM_IN` input patterns.
- R3: `y_o` is `ST_W`+1 bits wide: bit `ST_W` is always 0 and bits `ST_W`-1..0 carry the current state.
- R4: On each rising edge the state takes the value computed from the current state and `x_i` by passing through stage 0, then stage 1, and so on up to stage `LEVELS`-1; stage k+1 receives the partial state produced by stage k.
- R5: In a stage, the input-pick word addressed by the arriving partial state p gives an index j, and the stage tests bit `x_i[j]`; an index of `NUM_IN` or more tests a constant 0.
- R6: In a stage, the successor word read is the one at address {p, b}, with p in the upper `ST_W` bits and the tested bit b in bit 0; its value is the stage's outgoing partial state.
- R7: A write with `prog_we_i`=1 stores `prog_data_i` into exactly one word. The word is in stage `prog_lvl_i`. `prog_ram_i`=0 selects the input-pick memory, and the word is at address `prog_addr_i[ST_W-1:0]`. `prog_ram_i`=1 selects the successor memory, and the word is at address `prog_addr_i`. No other word changes.
- R8: A write presented before rising edge k does not affect the transition taken at edge k; the transition at edge k+1 already uses the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_i | input | NUM_IN | Machine inputs |
| prog_we_i | input | 1 | Write strobe for one memory word |
| prog_lvl_i | input | LVL_W | Stage index of the write |
| prog_ram_i | input | 1 | 0: input-pick memory, 1: successor memory |
| prog_addr_i | input | ST_W+1 | Word address of the write |
| prog_data_i | input | DATA_W | Word value of the write |
| y_o | output | ST_W+1 | Zero bit followed by the current state |

## Verification
The bench sweeps all 256 input patterns over the cleared machine. A block that fails to clear a memory, or that feeds raw inputs into the state, would leave state 0 there. It then programs every word of both stages and runs long pseudo-random input streams against its own arithmetic model. A swapped address order in the successor memory, stages chained in the wrong order, or a write landing in the wrong stage or memory each show up as a diverging state. Writes issued during running transitions catch a block that lets a new word reach the transition of the same edge. A reset in mid-run followed by more input traffic catches a block whose memories survive reset.

// File: rtl/rfsm_pkg.sv
package rfsm_pkg;

  typedef enum logic {
    RAM_PICK = 1'b0,
    RAM_SUCC = 1'b1
  } ram_kind_e;

  function automatic int unsigned bits_for(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) < n) w++;
    return w;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rfsm_rst_sync.sv
module rfsm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/rfsm_ram.sv
module rfsm_ram #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [DEPTH-1:0][DW-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (we_i) begin
      mem_d[waddr_i] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q <= mem_d;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R7
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

  // R7
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mem_q));

endmodule

// File: rtl/rfsm_level.sv
module rfsm_level #(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned ST_W   = 3,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_we_i,
  input  logic              succ_we_i,
  input  logic [ST_W:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NUM_IN-1:0] x_i,
  input  logic [ST_W-1:0]   st_i,
  output logic [ST_W-1:0]   st_o
);

  localparam int unsigned PAD_N = 1 << SEL_W;

  logic [PAD_N-1:0] x_pad;
  logic [SEL_W-1:0] pick_idx;
  logic             tested_bit;
  logic [ST_W:0]    succ_raddr;

  // Inputs beyond NUM_IN read as zero (R5)
  if (PAD_N == NUM_IN) begin : g_no_pad
    assign x_pad = x_i;
  end else begin : g_pad
    assign x_pad = {{(PAD_N - NUM_IN){1'b0}}, x_i};
  end

  rfsm_ram #(
    .AW (ST_W),
    .DW (SEL_W)
  ) pick_ram_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (pick_we_i),
    .waddr_i (wr_addr_i[ST_W-1:0]),
    .wdata_i (wr_data_i[SEL_W-1:0]),
    .raddr_i (st_i),
    .rdata_o (pick_idx)
  );

  assign tested_bit = x_pad[pick_idx];
  // Partial state in the upper address bits, tested bit at bit 0 (R6)
  assign succ_raddr = {st_i, tested_bit};

  rfsm_ram #(
    .AW (ST_W + 1),
    .DW (ST_W)
  ) succ_ram_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (succ_we_i),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i[ST_W-1:0]),
    .raddr_i (succ_raddr),
    .rdata_o (st_o)
  );

endmodule

// File: rtl/rfsm_top.sv
module rfsm_top
  import rfsm_pkg::*;
#(
  parameter int unsigned NUM_IN = 8,
  parameter int unsigned ST_W   = 3,
  parameter int unsigned LEVELS = 2,
  localparam int unsigned SEL_W  = bits_for(NUM_IN),
  localparam int unsigned DATA_W = max_of(ST_W, SEL_W),
  localparam int unsigned LVL_W  = bits_for(LEVELS),
  localparam int unsigned Y_W    = ST_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] x_i,
  input  logic              prog_we_i,
  input  logic [LVL_W-1:0]  prog_lvl_i,
  input  logic              prog_ram_i,
  input  logic [ST_W:0]     prog_addr_i,
  input  logic [DATA_W-1:0] prog_data_i,
  output logic [Y_W-1:0]    y_o
);

  logic                rst_int_n;
  logic [LEVELS-1:0]   pick_we;
  logic [LEVELS-1:0]   succ_we;
  logic [ST_W-1:0]     chain [LEVELS+1];
  logic [ST_W-1:0]     state_q;
  logic [ST_W-1:0]     state_d;

  rfsm_rst_sync rst_sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_int_n)
  );

  // Write decode: one word of one memory per cycle (R7)
  always_comb begin
    for (int l = 0; l < LEVELS; l++) begin
      pick_we[l] = prog_we_i && (prog_lvl_i == LVL_W'(l))
                   && (ram_kind_e'(prog_ram_i) == RAM_PICK);
      succ_we[l] = prog_we_i && (prog_lvl_i == LVL_W'(l))
                   && (ram_kind_e'(prog_ram_i) == RAM_SUCC);
    end
  end

  assign chain[0] = state_q;

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    rfsm_level #(
      .NUM_IN (NUM_IN),
      .ST_W   (ST_W),
      .SEL_W  (SEL_W),
      .DATA_W (DATA_W)
    ) level_i (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .pick_we_i (pick_we[l]),
      .succ_we_i (succ_we[l]),
      .wr_addr_i (prog_addr_i),
      .wr_data_i (prog_data_i),
      .x_i       (x_i),
      .st_i      (chain[l]),
      .st_o      (chain[l+1])
    );
  end

  always_comb begin
    state_d = chain[LEVELS];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= '0;
    end else begin
      state_q <= state_d;
    end
  end

  assign y_o = {1'b0, state_q};

  // R7
  one_ram_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({pick_we, succ_we}));

  // R4
  self_loop_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (chain[LEVELS] == state_q) |=> $stable(state_q));

  // R7
  wr_needs_we_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !prog_we_i |-> ({pick_we, succ_we} == '0));

endmodule

// File: tb/rfsm_tb_top.sv
module rfsm_top_tb_top;

  localparam int NUM_IN = 8;
  localparam int ST_W   = 3;
  localparam int LEVELS = 2;
  localparam int PICK_N = 1 << ST_W;
  localparam int SUCC_N = 1 << (ST_W + 1);

  logic              clk;
  logic              rst_n;
  logic [NUM_IN-1:0] x_i;
  logic              prog_we_i;
  logic [0:0]        prog_lvl_i;
  logic              prog_ram_i;
  logic [ST_W:0]     prog_addr_i;
  logic [2:0]        prog_data_i;
  logic [ST_W:0]     y_o;

  rfsm_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .x_i         (x_i),
    .prog_we_i   (prog_we_i),
    .prog_lvl_i  (prog_lvl_i),
    .prog_ram_i  (prog_ram_i),
    .prog_addr_i (prog_addr_i),
    .prog_data_i (prog_data_i),
    .y_o         (y_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int errs;
  int checks;
  int m_state;
  int pick_m [LEVELS][PICK_N];
  int succ_m [LEVELS][SUCC_N];
  logic [15:0] lfsr;

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int model_next(input int s, input logic [NUM_IN-1:0] x);
    int p;
    p = s;
    for (int l = 0; l < LEVELS; l++) begin
      int idx;
      int b;
      idx = pick_m[l][p];
      b = (idx < NUM_IN) ? int'(x[idx]) : 0;
      p = succ_m[l][p * 2 + b];
    end
    return p;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: y_o actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int l = 0; l < LEVELS; l++) begin
      for (int a = 0; a < PICK_N; a++) pick_m[l][a] = 0;
      for (int a = 0; a < SUCC_N; a++) succ_m[l][a] = 0;
    end
    m_state = 0;
  endtask

  // Starts and ends at a falling edge
  task automatic step(input string tag, input logic [NUM_IN-1:0] x,
                      input bit we, input int lvl, input bit ram,
                      input int addr, input int data);
    int nxt;
    chk(tag, int'(y_o), m_state);
    x_i         = x;
    prog_we_i   = we;
    prog_lvl_i  = 1'(lvl);
    prog_ram_i  = ram;
    prog_addr_i = 4'(addr);
    prog_data_i = 3'(data);
    nxt = model_next(m_state, x);
    if (we) begin
      if (!ram) pick_m[lvl][addr % PICK_N] = data;
      else      succ_m[lvl][addr] = data;
    end
    @(posedge clk);
    m_state = nxt;
    @(negedge clk);
    prog_we_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", int'(y_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clear_model();
    chk("R1 after release", int'(y_o), 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    errs = 0;
    checks = 0;
    lfsr = 16'hACE1;
    x_i = '0;
    prog_we_i = 1'b0;
    prog_lvl_i = '0;
    prog_ram_i = 1'b0;
    prog_addr_i = '0;
    prog_data_i = '0;
    clear_model();
    @(negedge clk);
    do_reset();

    // R2: cleared memories hold state 0 for every input pattern
    for (int v = 0; v < 256; v++) begin
      step("R2", 8'(v), 1'b0, 0, 1'b0, 0, 0);
    end

    // R7: program every word of both stages while inputs move
    for (int l = 0; l < LEVELS; l++) begin
      for (int s = 0; s < PICK_N; s++) begin
        lfsr = lfsr_next(lfsr);
        step("R7", lfsr[7:0], 1'b1, l, 1'b0, s,
             (l == 0) ? (s * 3 + 1) % 8 : 7 - s);
      end
      for (int a = 0; a < SUCC_N; a++) begin
        int s;
        int b;
        s = a / 2;
        b = a % 2;
        lfsr = lfsr_next(lfsr);
        if (l == 0)
          step("R7", lfsr[7:0], 1'b1, l, 1'b1, a, (b != 0) ? (s + 1) % 8 : (s ^ 5));
        else
          step("R7", lfsr[7:0], 1'b1, l, 1'b1, a, (b != 0) ? s : (s + 3) % 8);
      end
    end

    // R4 / R6: run the programmed machine on pseudo-random inputs
    for (int i = 0; i < 800; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R4 R6 run", lfsr[7:0], 1'b0, 0, 1'b0, 0, 0);
    end

    // R5: rewrite input-pick words while running
    for (int i = 0; i < 200; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R5", lfsr[7:0], (i % 2) == 0, int'(lfsr[8]), 1'b0,
           int'(lfsr[11:9]), int'(lfsr[14:12]));
    end

    // R8: writes to both memories alongside live transitions
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R8", lfsr[7:0], (i % 3) != 2, int'(lfsr[15]), lfsr[8],
           int'(lfsr[12:9]), int'(lfsr[14:12]) ^ i % 8);
    end

    // R3: y_o upper bit stays 0 (whole-word compare)
    for (int i = 0; i < 64; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R3", lfsr[7:0], 1'b0, 0, 1'b0, 0, 0);
    end

    // R1: reset in mid-run discards programming
    do_reset();
    for (int i = 0; i < 100; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R1 post-reset", lfsr[7:0], 1'b0, 0, 1'b0, 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule